// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

The block links two parallel buses, A and B, and carries data between them in either direction. Each direction owns one storage register. The A-to-B register loads from the A bus when its capture strobe rises. The B-to-A register loads from the B bus when its own strobe rises. The two strobes work apart from each other.

A per-direction select decides what the receiving bus gets. It gets either the live data from the opposite bus or the contents of that direction's register. An active-low output enable and a direction input decide which bus, if either, is driven. The bidirectional pins appear as separate input, output and output-enable vectors.

The block runs on one fabric clock with a synchronous active-high reset. The capture strobes are sampled on that clock, and a capture happens on a sampled low-to-high transition. All outputs are registered, so they show the inputs from the previous clock edge. Captures keep working while both buses are undriven, so the block can store data with its outputs disabled.

Top module: `xcvr_reg_bus`

## Requirements
- R1: While `rst` is high at a clock edge, both registers and all outputs are cleared to zero after that edge, so no bus is driven.
- R2: When `cap_ab` is sampled high at an edge and was sampled low at the previous edge, the A-to-B register takes the `a_in` value from that edge.
- R3: When `cap_ba` is sampled high at an edge and was sampled low at the previous edge, the B-to-A register takes the `b_in` value from that edge.
- R4: A strobe that stays high or stays low causes no capture, and the register keeps its value.
- R5: With `oe_n` = 1 at an edge, `a_oe` and `b_oe` are both 0 after that edge.
- R6: With `oe_n` = 0 at an edge, `dir` = 1 gives `b_oe` = 1 and `a_oe` = 0, and `dir` = 0 gives `a_oe` = 1 and `b_oe` = 0.
- R7: After an edge, `b_out` shows `a_in` from that edge when `sel_ab` = 0. When `sel_ab` = 1, it shows the A-to-B register as it was before that edge. `b_out` carries this value whether or not it is enabled.
- R8: After an edge, `a_out` shows `b_in` from that edge when `sel_ba` = 0. When `sel_ba` = 1, it shows the B-to-A register as it was before that edge.
- R9: Captures work the same way when `oe_n` = 1.
- R10: `a_oe` and `b_oe` are never both 1.
- R11: Rising edges on both strobes at the same clock edge load both registers, each from its own bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst | input | 1 | Synchronous reset, active high |
| oe_n | input | 1 | Output enable, active low |
| dir | input | 1 | 1 drives B from A, 0 drives A from B |
| sel_ab | input | 1 | 1 selects stored A-to-B data for B, 0 selects live A |
| sel_ba | input | 1 | 1 selects stored B-to-A data for A, 0 selects live B |
| cap_ab | input | 1 | Capture strobe for the A-to-B register |
| cap_ba | input | 1 | Capture strobe for the B-to-A register |
| a_in | input | W | Data read from the A bus |
| b_in | input | W | Data read from the B bus |
| a_out | output | W | Data to drive onto the A bus |
| a_oe | output | 1 | Drive enable for the A bus |
| b_out | output | W | Data to drive onto the B bus |
| b_oe | output | 1 | Drive enable for the B bus |

## Verification
The assertions check the following on every cycle:
- The one-driven-bus rule.
- Isolation when the enable is inactive.
- Register load on a strobe rise, and hold when there is none.
- The live pass-through path of each multiplexer.

Only the bench scenarios can show that:
- A strobe held high over several edges loads just once.
- A stored value survives a period of isolation and then appears on the other bus.
- Simultaneous strobes load both registers from their own buses.

The bench also sweeps every enable, direction and select combination against its reference model.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  typedef struct packed {
    logic a_en;
    logic b_en;
  } drive_t;

  function automatic drive_t drive_decode(input logic oe_n, input logic dir);
    drive_t d;
    d.a_en = ~oe_n & ~dir;
    d.b_en = ~oe_n & dir;
    return d;
  endfunction

endpackage

// File: rtl/xcvr_capture_reg.sv
module xcvr_capture_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         strobe,
  input  logic [W-1:0] din,
  output logic [W-1:0] q
);

  logic strobe_q;
  logic load;

  assign load = strobe & ~strobe_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      strobe_q <= 1'b0;
      q        <= '0;
    end else begin
      strobe_q <= strobe;
      if (load) q <= din;
    end
  end

  // R2 R3 R9 R11
  cap_load_chk: assert property (@(posedge clk) disable iff (rst)
    (strobe && !strobe_q) |=> (q == $past(din)));

  // R4
  cap_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(strobe && !strobe_q) |=> $stable(q));

endmodule

// File: rtl/xcvr_drive_ctl.sv
module xcvr_drive_ctl
  import xcvr_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic oe_n,
  input  logic dir,
  output logic a_oe,
  output logic b_oe
);

  drive_t nxt;

  always_comb nxt = drive_decode(oe_n, dir);

  always_ff @(posedge clk) begin
    if (rst) begin
      a_oe <= 1'b0;
      b_oe <= 1'b0;
    end else begin
      a_oe <= nxt.a_en;
      b_oe <= nxt.b_en;
    end
  end

  // R10
  one_bus_chk: assert property (@(posedge clk) !(a_oe && b_oe));

  // R5
  isolate_chk: assert property (@(posedge clk) disable iff (rst)
    oe_n |=> (!a_oe && !b_oe));

  // R6
  dir_b_chk: assert property (@(posedge clk) disable iff (rst)
    (!oe_n && dir) |=> (b_oe && !a_oe));

  // R1
  rst_off_chk: assert property (@(posedge clk)
    rst |=> (!a_oe && !b_oe));

endmodule

// File: rtl/xcvr_out_mux.sv
module xcvr_out_mux #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sel,
  input  logic [W-1:0] live,
  input  logic [W-1:0] stored,
  output logic [W-1:0] dout
);

  logic [W-1:0] pick;

  always_comb pick = sel ? stored : live;

  always_ff @(posedge clk) begin
    if (rst) dout <= '0;
    else     dout <= pick;
  end

  // R7 R8
  live_path_chk: assert property (@(posedge clk) disable iff (rst)
    !sel |=> (dout == $past(live)));

  // R1
  rst_zero_chk: assert property (@(posedge clk)
    rst |=> (dout == '0));

endmodule

// File: rtl/xcvr_reg_bus.sv
module xcvr_reg_bus #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         oe_n,
  input  logic         dir,
  input  logic         sel_ab,
  input  logic         sel_ba,
  input  logic         cap_ab,
  input  logic         cap_ba,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] a_out,
  output logic         a_oe,
  output logic [W-1:0] b_out,
  output logic         b_oe
);

  localparam int NDIR = 2;

  logic [NDIR-1:0]        strobe_v;
  logic [NDIR-1:0]        sel_v;
  logic [NDIR-1:0][W-1:0] src_v;
  logic [NDIR-1:0][W-1:0] held_v;
  logic [NDIR-1:0][W-1:0] out_v;

  // index 0: A to B, index 1: B to A
  assign strobe_v = {cap_ba, cap_ab};
  assign sel_v    = {sel_ba, sel_ab};
  assign src_v    = {b_in, a_in};

  for (genvar g = 0; g < NDIR; g++) begin : g_path
    xcvr_capture_reg #(.W(W)) i_cap (
      .clk    (clk),
      .rst    (rst),
      .strobe (strobe_v[g]),
      .din    (src_v[g]),
      .q      (held_v[g])
    );

    xcvr_out_mux #(.W(W)) i_mux (
      .clk    (clk),
      .rst    (rst),
      .sel    (sel_v[g]),
      .live   (src_v[g]),
      .stored (held_v[g]),
      .dout   (out_v[g])
    );
  end

  assign b_out = out_v[0];
  assign a_out = out_v[1];

  xcvr_drive_ctl i_drv (
    .clk  (clk),
    .rst  (rst),
    .oe_n (oe_n),
    .dir  (dir),
    .a_oe (a_oe),
    .b_oe (b_oe)
  );

endmodule

// File: tb/test_xcvr_reg_bus.sv
`timescale 1ns/1ps
module test_xcvr_reg_bus;

  localparam int W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic oe_n = 1'b1, dir = 1'b0, sel_ab = 1'b0, sel_ba = 1'b0;
  logic cap_ab = 1'b0, cap_ba = 1'b0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic [W-1:0] a_out, b_out;
  logic a_oe, b_oe;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  xcvr_reg_bus #(.W(W)) i_xcvr_reg_bus (
    .clk(clk), .rst(rst), .oe_n(oe_n), .dir(dir),
    .sel_ab(sel_ab), .sel_ba(sel_ba), .cap_ab(cap_ab), .cap_ba(cap_ba),
    .a_in(a_in), .b_in(b_in), .a_out(a_out), .a_oe(a_oe),
    .b_out(b_out), .b_oe(b_oe)
  );

  // behavioural reference model
  int m_ab = 0, m_ba = 0, p_ab = 0, p_ba = 0;
  int e_a = 0, e_b = 0, e_aoe = 0, e_boe = 0;
  bit was_rst = 1;

  always @(posedge clk) begin
    was_rst = rst;
    if (rst) begin
      m_ab = 0; m_ba = 0; p_ab = 0; p_ba = 0;
      e_a = 0; e_b = 0; e_aoe = 0; e_boe = 0;
    end else begin
      e_b   = sel_ab ? m_ab : int'(a_in);
      e_a   = sel_ba ? m_ba : int'(b_in);
      e_aoe = (!oe_n && !dir) ? 1 : 0;
      e_boe = (!oe_n && dir) ? 1 : 0;
      if (cap_ab && p_ab == 0) m_ab = int'(a_in);
      if (cap_ba && p_ba == 0) m_ba = int'(b_in);
      p_ab = cap_ab ? 1 : 0;
      p_ba = cap_ba ? 1 : 0;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(posedge clk) begin
    #1;
    if (!done) begin
      if (was_rst) begin
        chk("R1 b_out", int'(b_out), 0);
        chk("R1 a_out", int'(a_out), 0);
        chk("R1 oe", int'({a_oe, b_oe}), 0);
      end else begin
        chk("R7 b_out", int'(b_out), e_b);
        chk("R8 a_out", int'(a_out), e_a);
        chk(e_aoe == 0 && e_boe == 0 ? "R5 a_oe" : "R6 a_oe", int'(a_oe), e_aoe);
        chk(e_aoe == 0 && e_boe == 0 ? "R5 b_oe" : "R6 b_oe", int'(b_oe), e_boe);
      end
      chk("R10 one bus", int'(a_oe && b_oe), 0);
    end
  end

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #100000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // reset with busy inputs
    a_in = 8'hFF; b_in = 8'hEE; oe_n = 1'b0; dir = 1'b1;
    tick; tick; tick;
    chk("R1 reset b_out", int'(b_out), 0);
    chk("R1 reset b_oe", int'(b_oe), 0);
    rst = 1'b0; cap_ab = 1'b0; cap_ba = 1'b0; oe_n = 1'b1;
    tick;

    // R2 + R9: capture A while isolated
    sel_ab = 1'b1; a_in = 8'h5A; cap_ab = 1'b1;
    tick;
    cap_ab = 1'b0; a_in = 8'h11;
    tick;
    chk("R2 stored A", int'(b_out), 8'h5A);
    chk("R9 isolated while storing", int'({a_oe, b_oe}), 0);

    // R4: strobe held high loads once
    a_in = 8'h22; cap_ab = 1'b1;
    tick;
    a_in = 8'h33;
    tick;
    cap_ab = 1'b0; a_in = 8'h44;
    tick;
    chk("R4 held strobe", int'(b_out), 8'h22);
    tick;
    chk("R4 low strobe", int'(b_out), 8'h22);

    // R3: capture B while isolated
    sel_ba = 1'b1; b_in = 8'hC3; cap_ba = 1'b1;
    tick;
    cap_ba = 1'b0; b_in = 8'h01;
    tick;
    chk("R3 stored B", int'(a_out), 8'hC3);

    // R11: simultaneous strobes
    a_in = 8'hA1; b_in = 8'hB2; cap_ab = 1'b1; cap_ba = 1'b1;
    tick;
    cap_ab = 1'b0; cap_ba = 1'b0; a_in = 8'h00; b_in = 8'h00;
    tick;
    chk("R11 A-to-B", int'(b_out), 8'hA1);
    chk("R11 B-to-A", int'(a_out), 8'hB2);

    // stored value driven out after isolation
    oe_n = 1'b0; dir = 1'b1;
    tick;
    chk("R6 drive B", int'({a_oe, b_oe}), 1);
    chk("R7 stored on B", int'(b_out), 8'hA1);
    dir = 1'b0;
    tick;
    chk("R6 drive A", int'({a_oe, b_oe}), 2);
    chk("R8 stored on A", int'(a_out), 8'hB2);

    // sweep every control combination with changing data and strobes
    for (int r = 0; r < 4; r++) begin
      for (int i = 0; i < 16; i++) begin
        {oe_n, dir, sel_ab, sel_ba} = 4'(i);
        a_in   = 8'(i * 37 + r * 11 + 5);
        b_in   = 8'(i * 53 + r * 7 + 9);
        cap_ab = 1'((i + r) % 3 == 0);
        cap_ba = 1'((i + 2 * r) % 4 == 1);
        tick;
      end
    end

    // live pass-through directed
    oe_n = 1'b0; dir = 1'b1; sel_ab = 1'b0; cap_ab = 1'b0; cap_ba = 1'b0;
    a_in = 8'h6D;
    tick;
    chk("R7 live A", int'(b_out), 8'h6D);
    sel_ba = 1'b0; b_in = 8'h92;
    tick;
    chk("R8 live B", int'(a_out), 8'h92);

    tick;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule